// File: doc/BRIEF.md
# Sign-Magnitude DAC Control Register Slave

This block is a two-wire serial (I2C) slave that holds one control byte for each of several current-output DAC channels. A bus master writes a byte to a channel by sending the device address, a memory address and one data byte. It can read any channel back, either after a repeated START or from the pointer left by the previous access. Each control byte is split into a direction line and a 7-bit magnitude. The magnitude goes straight to the analog DAC. A derived "active" flag is low whenever the magnitude is zero, because a zero magnitude yields no current in either direction.

The 7-bit device address has a fixed upper part and a low part taken from pin straps. Several copies can therefore share one bus. SCL and SDA are first brought into the system clock domain by a synchronizer. All protocol decisions are then made on the synchronized edges. SDA is handled as an open-drain line: the block only ever pulls it low, through an enable output.

Top module: `smdac_i2c_regs`

## Requirements
- R1: After reset every channel register is 00h. Every sign, magnitude and active output is low, and SDA is not driven.
- R2: The block responds to the 7-bit device address {1001 0, strap[1], strap[0]}. The address byte is that address followed by the R/W bit (0 = write). The block acknowledges a matching address byte by pulling SDA low during the ninth SCL pulse.
- R3: An address byte that does not match gets no acknowledge. Every later byte up to the next START is then ignored: it is not acknowledged and it writes nothing.
- R4: A write consists of START, the address byte with R/W = 0, a memory address byte, one data byte and STOP, with each byte acknowledged. Channel i is stored at memory address F8h + i.
- R5: Bit 7 of a channel register drives that channel's sign output (1 = source, 0 = sink). Bits 6:0 drive its magnitude output. The active output is high only when the magnitude is nonzero, whatever the sign.
- R6: A write to a memory address outside F8h..FBh is acknowledged but discarded. A read from such an address returns 00h.
- R7: A write of the memory address, then a repeated START, then the address byte with R/W = 1 returns the addressed register, most significant bit first. SDA changes only after SCL falls.
- R8: A read that sets no address returns the register selected by the memory pointer. Reads leave the pointer unchanged, so repeated reads return the same register.
- R9: A START inside a byte abandons that byte and restarts address reception. A STOP before the data byte leaves all registers unchanged.
- R10: SDA is only ever pulled low. The SDA enable changes only while SCL is low, and the channel outputs change only while SCL is high.
- R11: One write transaction changes at most one channel; the other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_o | output | 1 | Data driven onto SDA when enabled (always low) |
| sda_oe | output | 1 | High to pull SDA low |
| addr_strap | input | STRAP_W | Pin straps forming the low device-address bits |
| ch_sign | output | N_CH | Per-channel direction, 1 = source |
| ch_mag | output | N_CH*7 | Per-channel magnitude, channel i in bits 7i+6..7i |
| ch_active | output | N_CH | Per-channel nonzero-magnitude flag |

## Verification
The assertions assume a bus slow compared with the system clock. SCL must stay high and stay low for several clocks longer than the synchronizer and decode delay. SDA must change only while SCL is low, except when forming START and STOP. Under those conditions, register updates always land inside an SCL high phase, and acknowledge and data drive always change inside an SCL low phase. The bench master uses quarter-bit spacing of ten clocks and moves SDA only between SCL pulses. It never lets a master bit collide with a slave drive, so the assumptions hold throughout the stimulus.

// File: rtl/smdac_pkg.sv
package smdac_pkg;
   localparam int BYTE_W = 8;
   localparam int MAG_W  = BYTE_W - 1;
   localparam int BIT_CW = $clog2(BYTE_W);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_DEVACK,
      ST_MEMADR,
      ST_MEMACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_PARK
   } smdac_state_e;
endpackage

// File: rtl/smdac_sync.sv
module smdac_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s    = scl_sh[STAGES-1];
   assign sda_s    = sda_sh[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smdac_engine.sv
module smdac_engine import smdac_pkg::*; #(
   parameter int           STRAP_W   = 2,
   parameter logic [6:0]   DEV_ADDR7 = 7'h48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_ev,
   input  logic               stop_ev,
   input  logic [STRAP_W-1:0] strap,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic [BYTE_W-1:0]  ptr,
   output logic               wr_en,
   output logic [BYTE_W-1:0]  wr_data,
   output logic               sda_oe
);
   smdac_state_e        st;
   logic [BYTE_W-1:0]   shreg;
   logic [BIT_CW-1:0]   bitcnt;
   logic                rw_q;
   logic [BYTE_W-1:0]   rx_byte;
   logic                dev_hit;
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

   assign rx_byte = {shreg[BYTE_W-2:0], sda_s};
   assign dev_hit = (rx_byte[BYTE_W-1:1] == {DEV_ADDR7[6:STRAP_W], strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         shreg   <= '0;
         bitcnt  <= '0;
         rw_q    <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_ev) begin
            st     <= ST_DEVADR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_DEVADR, ST_MEMADR, ST_WDATA: begin
                  if (scl_rise) begin
                     shreg <= rx_byte;
                     if (bitcnt == LAST_BIT) begin
                        bitcnt <= '0;
                        if (st == ST_DEVADR) begin
                           if (dev_hit) begin
                              rw_q <= rx_byte[0];
                              st   <= ST_DEVACK;
                           end else begin
                              st   <= ST_PARK;
                           end
                        end else if (st == ST_MEMADR) begin
                           ptr <= rx_byte;
                           st  <= ST_MEMACK;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_data <= rx_byte;
                           st      <= ST_WACK;
                        end
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_DEVACK, ST_MEMACK, ST_WACK: begin
                  if (scl_fall) begin
                     if (bitcnt == '0) begin
                        sda_oe <= 1'b1;
                        bitcnt <= BIT_CW'(1);
                     end else begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        if (st == ST_DEVACK) begin
                           if (rw_q) begin
                              st     <= ST_RDATA;
                              sda_oe <= ~rd_data[BYTE_W-1];
                              shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                           end else begin
                              st <= ST_MEMADR;
                           end
                        end else if (st == ST_MEMACK) begin
                           st <= ST_WDATA;
                        end else begin
                           st <= ST_PARK;
                        end
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        st     <= ST_RACK;
                     end else begin
                        sda_oe <= ~shreg[BYTE_W-1];
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     if (sda_s) st <= ST_PARK;
                     else       bitcnt <= BIT_CW'(1);
                  end else if (scl_fall && bitcnt != '0) begin
                     bitcnt <= '0;
                     st     <= ST_RDATA;
                     sda_oe <= ~rd_data[BYTE_W-1];
                     shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smdac_bank.sv
module smdac_bank import smdac_pkg::*; #(
   parameter int               N_CH     = 4,
   parameter logic [BYTE_W-1:0] BASE_ADR = 8'hF8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [BYTE_W-1:0]     ptr,
   input  logic                  wr_en,
   input  logic [BYTE_W-1:0]     wr_data,
   output logic [BYTE_W-1:0]     rd_data,
   output logic [N_CH-1:0]       ch_sign,
   output logic [N_CH*MAG_W-1:0] ch_mag,
   output logic [N_CH-1:0]       ch_active
);
   localparam int IDX_W = $clog2(N_CH);

   logic [BYTE_W-1:0] regs [N_CH];
   logic [BYTE_W-1:0] off;
   logic              hit;
   logic [IDX_W-1:0]  idx;

   assign off = ptr - BASE_ADR;
   assign hit = (off < BYTE_W'(N_CH));
   assign idx = off[IDX_W-1:0];

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wr_en && hit && idx == IDX_W'(i))
            regs[i] <= wr_data;
      end
      assign ch_sign[i]                 = regs[i][BYTE_W-1];
      assign ch_mag[i*MAG_W +: MAG_W]   = regs[i][MAG_W-1:0];
      assign ch_active[i]               = |regs[i][MAG_W-1:0];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_CH; i++)
         if (hit && idx == IDX_W'(i)) rd_data = regs[i];
   end
endmodule

// File: rtl/smdac_i2c_regs.sv
module smdac_i2c_regs import smdac_pkg::*; #(
   parameter int                N_CH        = 4,
   parameter int                SYNC_STAGES = 2,
   parameter int                STRAP_W     = 2,
   parameter logic [6:0]        DEV_ADDR7   = 7'h48,
   parameter logic [BYTE_W-1:0] BASE_ADR    = 8'hF8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_o,
   output logic                  sda_oe,
   input  logic [STRAP_W-1:0]    addr_strap,
   output logic [N_CH-1:0]       ch_sign,
   output logic [N_CH*MAG_W-1:0] ch_mag,
   output logic [N_CH-1:0]       ch_active
);
   if (N_CH < 2 || N_CH > 16) begin : g_bad_nch
      $error("N_CH out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("STRAP_W out of range");
   end
   if (int'(BASE_ADR) + N_CH > 256) begin : g_bad_base
      $error("register window exceeds memory address space");
   end

   logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic [BYTE_W-1:0] ptr, rd_data, wr_data;
   logic              wr_en;

   smdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   smdac_engine #(.STRAP_W(STRAP_W), .DEV_ADDR7(DEV_ADDR7)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .strap    (addr_strap),
      .rd_data  (rd_data),
      .ptr      (ptr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .sda_oe   (sda_oe)
   );

   smdac_bank #(.N_CH(N_CH), .BASE_ADR(BASE_ADR)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr       (ptr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .ch_sign   (ch_sign),
      .ch_mag    (ch_mag),
      .ch_active (ch_active)
   );

   assign sda_o = 1'b0;
endmodule

// File: rtl/smdac_i2c_regs_chk.sv
module smdac_i2c_regs_chk #(
   parameter int N_CH  = 4,
   parameter int MAG_W = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_i,
   input logic                  sda_oe,
   input logic [N_CH-1:0]       ch_sign,
   input logic [N_CH*MAG_W-1:0] ch_mag
);
   logic [N_CH-1:0]       prev_sign;
   logic [N_CH*MAG_W-1:0] prev_mag;
   logic [N_CH-1:0]       chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sign <= '0;
         prev_mag  <= '0;
      end else begin
         prev_sign <= ch_sign;
         prev_mag  <= ch_mag;
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_chg
      assign chg[i] = (ch_sign[i] != prev_sign[i]) ||
                      (ch_mag[i*MAG_W +: MAG_W] != prev_mag[i*MAG_W +: MAG_W]);
   end

   // R1: reset clears every channel and releases the bus
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (ch_sign == '0 && ch_mag == '0 && !sda_oe));

   // R10: channel outputs move only inside an SCL high phase
   a_r10_out_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ch_sign, ch_mag}) |-> scl_i);

   // R10: SDA drive changes only inside an SCL low phase
   a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R11: at most one channel changes at a time
   a_r11_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 1);
endmodule

bind smdac_i2c_regs smdac_i2c_regs_chk #(.N_CH(N_CH), .MAG_W(smdac_pkg::MAG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .ch_sign (ch_sign),
   .ch_mag  (ch_mag)
);

// File: tb/smdac_i2c_regs_tb.sv
module smdac_i2c_regs_tb;
   import smdac_pkg::*;

   localparam int N_CH = 4;
   localparam int Q    = 10;
   localparam int WD   = 150000;
   localparam logic [15:0] VEC [7] = '{16'hF8AA, 16'hF905, 16'hFA80, 16'hFB7F,
                                       16'hF9FF, 16'hFC55, 16'hF800};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic [1:0] strap = 2'b00;
   logic sda_o, sda_oe, sda_bus;
   logic [N_CH-1:0] ch_sign, ch_active;
   logic [N_CH*MAG_W-1:0] ch_mag;
   logic [7:0] model [N_CH];
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;
   assign sda_bus = sda_oe ? sda_o : m_sda;

   smdac_i2c_regs #(.N_CH(N_CH)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_o(sda_o), .sda_oe(sda_oe), .addr_strap(strap),
      .ch_sign(ch_sign), .ch_mag(ch_mag), .ch_active(ch_active));

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      for (int i = 0; i < N_CH; i++) begin
         chk(req, $sformatf("ch%0d sign", i), 32'(ch_sign[i]), 32'(model[i][7]));
         chk(req, $sformatf("ch%0d mag", i), 32'(ch_mag[i*MAG_W +: MAG_W]), 32'(model[i][6:0]));
         chk(req, $sformatf("ch%0d active", i), 32'(ch_active[i]), 32'(model[i][6:0] != 7'd0));
      end
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int k = 7; k > 7 - n; k--) begin
         m_sda = b[k]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
      ack = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int k = 7; k >= 0; k--) begin
         wq(Q); m_scl = 1'b1; wq(Q); b[k] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
      end
      m_sda = nack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
   endtask

   task automatic i2c_write(input logic [7:0] dev, input logic [7:0] a, input logic [7:0] d,
                            output logic [2:0] acks);
      i2c_start();
      send_byte(dev, acks[2]); send_byte(a, acks[1]); send_byte(d, acks[0]);
      i2c_stop();
      wq(8);
   endtask

   task automatic read_rs(input logic [7:0] a, output logic [7:0] v);
      logic ack;
      i2c_start(); send_byte(8'h90, ack); send_byte(a, ack);
      i2c_start(); send_byte(8'h91, ack);
      recv_byte(1'b1, v); i2c_stop();
   endtask

   task automatic read_cur(output logic [7:0] v);
      logic ack;
      i2c_start(); send_byte(8'h91, ack);
      chk("R8", "current read address ack", 32'(ack), 32'd0);
      recv_byte(1'b1, v); i2c_stop();
   endtask

   task automatic set_model(input logic [7:0] a, input logic [7:0] d);
      if (a >= 8'hF8 && a <= 8'hFB) model[a - 8'hF8] = d;
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL all requirements watchdog: actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [2:0] acks;
      logic [7:0] v, a, d;
      logic ack;
      for (int i = 0; i < N_CH; i++) model[i] = 8'h00;
      wq(10); rst_n = 1'b1; wq(10);

      // R1 reset state, R10 open drain
      check_outputs("R1");
      chk("R1", "sda_oe after reset", 32'(sda_oe), 32'd0);
      chk("R10", "sda_o level", 32'(sda_o), 32'd0);

      // vector table: write, outputs, read back
      for (int n = 0; n < 7; n++) begin
         a = VEC[n][15:8]; d = VEC[n][7:0];
         i2c_write(8'h90, a, d, acks);
         chk("R2 R4", $sformatf("write acks vec%0d", n), 32'(acks), 32'd0);
         set_model(a, d);
         check_outputs("R4 R5 R6 R11");
         read_rs(a, v);
         chk("R6 R7", $sformatf("readback of %0h", a), 32'(v),
             (a >= 8'hF8 && a <= 8'hFB) ? 32'(model[a - 8'hF8]) : 32'd0);
      end

      // R8 current-address read after selecting FB
      read_rs(8'hFB, v);
      read_cur(v);
      chk("R8", "first current read", 32'(v), 32'(model[3]));
      read_cur(v);
      chk("R8", "second current read", 32'(v), 32'(model[3]));

      // R3 mismatched address, rest of transaction ignored
      i2c_start();
      send_byte(8'h92, ack); chk("R3", "mismatch addr ack", 32'(ack), 32'd1);
      send_byte(8'hF9, ack); chk("R3", "ignored memaddr ack", 32'(ack), 32'd1);
      send_byte(8'h33, ack); chk("R3", "ignored data ack", 32'(ack), 32'd1);
      i2c_stop(); wq(8);
      check_outputs("R3");

      // R2 straps move the device address
      strap = 2'b11; wq(4);
      i2c_write(8'h96, 8'hF8, 8'h5A, acks);
      chk("R2", "strapped write acks", 32'(acks), 32'd0);
      set_model(8'hF8, 8'h5A);
      check_outputs("R2");
      i2c_write(8'h90, 8'hF8, 8'h11, acks);
      chk("R2", "old address ack", 32'(acks[2]), 32'd1);
      check_outputs("R2");
      strap = 2'b00; wq(4);

      // R9 START inside a byte restarts reception
      i2c_start(); send_bits(8'hA5, 4);
      i2c_start();
      send_byte(8'h90, acks[2]); send_byte(8'hFA, acks[1]); send_byte(8'h3C, acks[0]);
      i2c_stop(); wq(8);
      chk("R9", "acks after aborted byte", 32'(acks), 32'd0);
      set_model(8'hFA, 8'h3C);
      check_outputs("R9");

      // R9 STOP before data leaves registers unchanged
      i2c_start(); send_byte(8'h90, ack); send_byte(8'hF9, ack); i2c_stop(); wq(8);
      check_outputs("R9");
      read_cur(v);
      chk("R8 R9", "pointer after stopped write", 32'(v), 32'(model[1]));

      // R1 reset in mid-run clears all channels
      wq(4); rst_n = 1'b0; wq(4); rst_n = 1'b1; wq(8);
      for (int i = 0; i < N_CH; i++) model[i] = 8'h00;
      check_outputs("R1");
      read_rs(8'hF9, v);
      chk("R1", "readback after reset", 32'(v), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule